// File: doc/BRIEF.md
# Byte-Phased Table CRC Folding Engine

This block condenses a byte stream into a 32-bit check word at a rate of one byte per clock. Every accepted byte addresses a 256-entry, 32-bit constant table built during elaboration from the reflected polynomial 0xEDB88320, so no memory image is needed. The table output is registered. A binary byte counter supplies a 2-bit phase that controls a registered merge stage. On phases 0, 1 and 2 the merge stage keeps its running word unchanged. On phase 3 it folds the registered table entry into that word with XOR. Between any two registers there is at most one table read or one level of select-plus-XOR logic. That short path is what lets the engine reach 100 MHz, which is 100 MB/s.

A frame opens with a start strobe. The strobe clears the byte counter and loads the running word with all ones. The output is the inverted running word. The result is therefore the XOR of the table entries for the bytes at frame positions 3, 7, 11 and so on, counting from 0. A small controller tracks whether a frame is open and whether a byte is still in the pipeline. It raises a done flag once every accepted byte has been merged.

Controller states:
- IDLE: no frame is open.
- OPEN: a frame has started but no byte has arrived yet.
- BUSY: a byte sits between the table register and the merge stage.
- DONE: at least one byte has arrived and all of them are merged.

Controller transitions:
- A start strobe wins in every state. It goes to BUSY when a byte comes with it, and to OPEN otherwise.
- Without a start strobe, IDLE stays in IDLE.
- OPEN goes to BUSY on a valid byte.
- BUSY and DONE go to BUSY on a valid byte, and to DONE otherwise.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset, done is 0 and crc_out is 0x00000000, which is the inverted all-ones preset.
- R2: The byte counter is 0 for the first byte of a frame and steps by one for each accepted byte. Its two low bits are the byte's phase, taking the values 0, 1, 2, 3, 0 and so on.
- R3: A byte on phase 0, 1 or 2 leaves the running word unchanged. A frame of exactly three bytes gives crc_out = 0x00000000.
- R4: A byte on phase 3 XORs table entry T[byte] into the running word. A four-byte frame ending in 0x01 gives 0x77073096, and one ending in 0xFF gives 0x2D02EF8D.
- R5: Table entry T[x] equals x shifted right eight times. On each shift, 0xEDB88320 is XORed in whenever the bit shifted out was 1. This holds for all 256 byte values.
- R6: While in_valid is low, the byte counter and the running word hold. Idle gaps anywhere in a frame do not change the result, and crc_out stays constant during a gap.
- R7: A start strobe clears the counter and presets the running word in the same cycle. A byte still in the pipeline from the old frame is discarded. A byte that comes with the start strobe is phase 0 of the new frame. The cycle after a start strobe shows crc_out = 0x00000000.
- R8: Bytes that arrive while no frame is open are ignored. done stays 0 and crc_out stays 0x00000000.
- R9: done is 0 while a byte is in the pipeline and right after a start strobe. It becomes 1 one clock after the last accepted byte has been captured, which is when crc_out shows the merged result. It stays 1 until the next byte or start strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Data byte |
| in_valid | input | 1 | in_byte carries a byte this cycle |
| sof | input | 1 | Start of frame: clear the counter and preset the running word |
| crc_out | output | 32 | Inverted running word |
| done | output | 1 | All accepted bytes of the open frame are merged |

## Verification
The bench sweeps every byte value through the phase-3 position. A wrong polynomial, a wrong shift direction or a table entry at the wrong address would all show up as a miscompare on some values. Frames of three and four bytes, plus longer frames with idle gaps, expose a counter that is off by one, that folds on the wrong phase, or that advances while no byte is valid: the fold would land on a different byte and the result would move. A start strobe issued while a phase-3 byte from the old frame is still in the pipeline catches a design that lets that byte leak into the new frame. Bytes sent with no frame open, and the done flag sampled one cycle after capture, catch a controller that accepts stray data or announces completion too early.

// File: rtl/crc_byte_pkg.sv
package crc_byte_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_BUSY = 2'd2,
        ST_DONE = 2'd3
    } eng_state_e;

endpackage

// File: rtl/crc_lut.sv
module crc_lut #(
    parameter int              CRC_W  = 32,
    parameter int              BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY  = 32'hEDB88320
) (
    input  logic              clk,
    input  logic              en,
    input  logic [BYTE_W-1:0] idx,
    output logic [CRC_W-1:0]  q
);
    localparam int DEPTH = 1 << BYTE_W;

    typedef logic [CRC_W-1:0] tbl_t [DEPTH];

    // Each entry is the index pushed through BYTE_W reflected shift steps.
    function automatic tbl_t build_tbl();
        tbl_t t;
        for (int i = 0; i < DEPTH; i++) begin
            logic [CRC_W-1:0] c;
            c = CRC_W'(i);
            for (int k = 0; k < BYTE_W; k++) begin
                c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
            end
            t[i] = c;
        end
        return t;
    endfunction

    localparam tbl_t TBL = build_tbl();

    always_ff @(posedge clk) begin
        if (en) begin
            q <= TBL[idx];
        end
    end

endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [SEL_W-1:0] sel
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= inc ? ONE : '0;
        end else if (inc) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign sel = cnt_q[SEL_W-1:0];

endmodule

// File: rtl/merge_reg.sv
module merge_reg #(
    parameter int               W      = 32,
    parameter logic [W-1:0]     PRESET = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         en,
    input  logic         fold,
    input  logic [W-1:0] b,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || load) begin
                q[i] <= PRESET[i];
            end else if (en) begin
                q[i] <= fold ? (q[i] ^ b[i]) : q[i];
            end
        end
    end

endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
    import crc_byte_pkg::*;
#(
    parameter int               CRC_W  = 32,
    parameter int               BYTE_W = 8,
    parameter int               CNT_W  = 16,
    parameter int               SEL_W  = 2,
    parameter logic [CRC_W-1:0] POLY   = 32'hEDB88320
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              sof,
    output logic [CRC_W-1:0]  crc_out,
    output logic              done
);
    localparam logic [CRC_W-1:0] PRESET = '1;

    eng_state_e       st, st_nx;
    logic             accept;
    logic [SEL_W-1:0] cnt_sel;
    logic [SEL_W-1:0] byte_phase;
    logic [SEL_W-1:0] ph_q;
    logic [CRC_W-1:0] tbl_q;
    logic [CRC_W-1:0] run_q;

    assign accept     = in_valid && (sof || (st != ST_IDLE));
    assign byte_phase = sof ? '0 : cnt_sel;

    phase_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (sof),
        .inc (accept),
        .sel (cnt_sel)
    );

    crc_lut #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY)) u_lut (
        .clk (clk),
        .en  (accept),
        .idx (in_byte),
        .q   (tbl_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
        end else if (accept) begin
            ph_q <= byte_phase;
        end
    end

    merge_reg #(.W(CRC_W), .PRESET(PRESET)) u_merge (
        .clk  (clk),
        .rst  (rst),
        .load (sof),
        .en   (st == ST_BUSY),
        .fold (&ph_q),
        .b    (tbl_q),
        .q    (run_q)
    );

    always_comb begin
        st_nx = st;
        if (sof) begin
            st_nx = in_valid ? ST_BUSY : ST_OPEN;
        end else begin
            unique case (st)
                ST_IDLE: st_nx = ST_IDLE;
                ST_OPEN: st_nx = in_valid ? ST_BUSY : ST_OPEN;
                ST_BUSY: st_nx = in_valid ? ST_BUSY : ST_DONE;
                ST_DONE: st_nx = in_valid ? ST_BUSY : ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        done    = (st == ST_DONE);
        crc_out = ~run_q;
    end

endmodule

// File: rtl/crc_byte_engine_chk.sv
module crc_byte_engine_chk
    import crc_byte_pkg::*;
#(
    parameter int CRC_W = 32,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             sof,
    input logic [CRC_W-1:0] crc_out,
    input logic             done,
    input eng_state_e       st,
    input logic [SEL_W-1:0] cnt_sel,
    input logic [SEL_W-1:0] ph_q
);
    logic acc_c;
    assign acc_c = in_valid && (st != ST_IDLE);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!done && crc_out == '0));

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (acc_c && !sof) |=> (cnt_sel == SEL_W'($past(cnt_sel) + 1'b1)));

    a_r2_sof_count: assert property (@(posedge clk) disable iff (rst)
        (sof && in_valid) |=> (cnt_sel == SEL_W'(1) && ph_q == '0));

    a_r3_pass_through: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && ph_q != '1 && !sof) |=> $stable(crc_out));

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !sof && st != ST_BUSY) |=> ($stable(crc_out) && $stable(cnt_sel)));

    a_r7_sof_preset: assert property (@(posedge clk) disable iff (rst)
        sof |=> (crc_out == '0 && !done));

    a_r8_idle_ignore: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !sof) |=> (!done && $stable(crc_out) && $stable(cnt_sel)));

    a_r9_done_rise: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && !in_valid && !sof) |=> done);

    a_r9_done_low: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (sof || st != ST_IDLE)) |=> !done);

endmodule

bind crc_byte_engine crc_byte_engine_chk #(.CRC_W(CRC_W), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .sof      (sof),
    .crc_out  (crc_out),
    .done     (done),
    .st       (st),
    .cnt_sel  (cnt_sel),
    .ph_q     (ph_q)
);

// File: tb/tb_crc_byte_engine.sv
module tb_crc_byte_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        sof = 1'b0;
    logic [31:0] crc_out;
    logic        done;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] m_acc;
    int          m_pos;

    always #4 clk = ~clk;

    crc_byte_engine dut (
        .clk      (clk),
        .rst      (rst),
        .in_byte  (in_byte),
        .in_valid (in_valid),
        .sof      (sof),
        .crc_out  (crc_out),
        .done     (done)
    );

    // Reference table entry: the byte shifted right eight times, one bit
    // at a time, with the polynomial XORed in whenever a 1 is shifted out.
    function automatic logic [31:0] ref_entry(input logic [7:0] v);
        logic [31:0] c;
        c = {24'h0, v};
        for (int k = 0; k < 8; k++) begin
            if (c[0]) c = (c >> 1) ^ 32'hEDB88320;
            else      c = c >> 1;
        end
        return c;
    endfunction

    task automatic model_start();
        m_acc = '0;
        m_pos = 0;
    endtask

    task automatic model_byte(input logic [7:0] b);
        if ((m_pos % 4) == 3) m_acc = m_acc ^ ref_entry(b);
        m_pos++;
    endtask

    task automatic chk32(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // All drive tasks begin and end at a falling edge.
    task automatic put(input logic s, input logic v, input logic [7:0] b);
        sof = s; in_valid = v; in_byte = b;
        @(negedge clk);
        sof = 1'b0; in_valid = 1'b0; in_byte = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input logic [7:0] b3);
        model_start();
        put(1'b1, 1'b1, b0); model_byte(b0);
        put(1'b0, 1'b1, b1); model_byte(b1);
        put(1'b0, 1'b1, b2); model_byte(b2);
        put(1'b0, 1'b1, b3); model_byte(b3);
        idle(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk1("R1 done after reset", done, 1'b0);
        chk32("R1 crc after reset", crc_out, 32'h0);

        // R8: bytes with no frame open are ignored
        put(1'b0, 1'b1, 8'h01); put(1'b0, 1'b1, 8'h02);
        put(1'b0, 1'b1, 8'h03); put(1'b0, 1'b1, 8'hFF);
        idle(1);
        chk1("R8 done with no frame", done, 1'b0);
        chk32("R8 crc with no frame", crc_out, 32'h0);

        // R7/R9: start strobe alone
        put(1'b1, 1'b0, 8'h00);
        chk1("R9 done after bare start", done, 1'b0);
        chk32("R7 crc after bare start", crc_out, 32'h0);

        // R9: in-flight byte holds done low; rises one clock later
        model_start();
        put(1'b0, 1'b1, 8'h10); model_byte(8'h10);
        chk1("R9 done low while byte in flight", done, 1'b0);
        idle(1);
        chk1("R9 done after merge", done, 1'b1);
        chk32("R3 one-byte frame", crc_out, 32'h0);
        idle(3);
        chk1("R9 done holds", done, 1'b1);

        // R3: three bytes, no fold
        model_start();
        put(1'b1, 1'b1, 8'hAA); put(1'b0, 1'b1, 8'h55); put(1'b0, 1'b1, 8'hFF);
        idle(1);
        chk32("R3 three-byte frame", crc_out, 32'h0);

        // R4/R2: known table entries at phase 3
        send_frame(8'h00, 8'h00, 8'h00, 8'h01);
        chk32("R4 fold of 0x01", crc_out, 32'h77073096);
        send_frame(8'h12, 8'h34, 8'h56, 8'hFF);
        chk32("R4 fold of 0xFF", crc_out, 32'h2D02EF8D);
        chk1("R9 done after four-byte frame", done, 1'b1);

        // R5: every byte value at phase 3
        for (int v = 0; v < 256; v++) begin
            send_frame(8'(v ^ 8'h5A), 8'(v + 3), ~8'(v), 8'(v));
            chk32($sformatf("R5 table sweep v=%0d", v), crc_out, m_acc);
        end

        // R2: long frames, several folds
        for (int p = 0; p < 8; p++) begin
            model_start();
            for (int i = 0; i < 13 + p; i++) begin
                logic [7:0] b;
                b = 8'((i * 37) + (p * 11) + 1);
                put(i == 0, 1'b1, b); model_byte(b);
            end
            idle(1);
            chk32($sformatf("R2 long frame p=%0d", p), crc_out, m_acc);
        end

        // R6: gaps of varying length do not matter; output steady in gaps
        model_start();
        for (int i = 0; i < 18; i++) begin
            logic [7:0] b;
            b = 8'((i * 29) ^ 8'hC3);
            put(i == 0, 1'b1, b); model_byte(b);
            if ((i % 3) == 2) begin
                idle(1);
                snap = crc_out;
                idle(1 + (i % 4));
                chk32($sformatf("R6 stable in gap i=%0d", i), crc_out, snap);
            end
        end
        idle(1);
        chk32("R6 gapped frame result", crc_out, m_acc);

        // R7: restart while a phase-3 byte of the old frame is in flight
        put(1'b1, 1'b1, 8'h01); put(1'b0, 1'b1, 8'h02);
        put(1'b0, 1'b1, 8'h03); put(1'b0, 1'b1, 8'hFF);
        model_start();
        put(1'b1, 1'b1, 8'h21); model_byte(8'h21);
        idle(1);
        chk32("R7 old in-flight byte dropped", crc_out, 32'h0);
        put(1'b0, 1'b1, 8'h22); model_byte(8'h22);
        put(1'b0, 1'b1, 8'h23); model_byte(8'h23);
        put(1'b0, 1'b1, 8'h01); model_byte(8'h01);
        idle(1);
        chk32("R7 restart counts strobe byte as phase 0", crc_out, 32'h77073096);
        chk32("R7 restart against model", crc_out, m_acc);

        // R7: restart mid-frame after bare strobe, then reset mid-frame (R1)
        put(1'b1, 1'b1, 8'h05); put(1'b0, 1'b1, 8'h06);
        put(1'b1, 1'b0, 8'h00);
        chk32("R7 bare restart clears word", crc_out, 32'h0);
        send_frame(8'h00, 8'h00, 8'h00, 8'hFF);
        chk32("R7 frame after bare restart", crc_out, 32'h2D02EF8D);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        chk1("R1 done after mid-run reset", done, 1'b0);
        chk32("R1 crc after mid-run reset", crc_out, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule